// File: doc/BRIEF.md
# Overlapping Frame Input Buffer

The block gathers a continuous stream of complex samples, one per clock at most, into frames for a downstream transform engine. Frames are 16, 64 or 256 points long. Consecutive frames can share none, half or three quarters of their samples. The samples sit in a circular dual-port store that holds two frame lengths. Loading goes on without a pause while an earlier frame is read out.

Each time a frame is complete the block raises a one-cycle ready pulse. It then streams that frame, oldest sample first, on a read port with a running index. The frame size and the overlap are sampled while the buffer is idle after reset. They are frozen from the first accepted sample until the next reset. When a frame completes while the previous readout still has more than its final sample to go, that frame is discarded and a sticky overrun flag rises.

Top module: `ovl_frame_buf`

## Requirements
- R1: After reset, `frame_ready`, `rd_valid` and `overrun` are low.
- R2: The first `frame_ready` is a single-cycle pulse. It is high in the cycle after the clock edge that accepts the N-th sample, where N is 16, 64 or 256 for `cfg_size` 0, 1 or 2. The value 3 selects 256.
- R3: After the first frame, a new frame is produced every H accepted samples. For `cfg_ovl` 0, 1 and 2, H is N, N/2 and N/4. The value 3 acts as 0.
- R4: In the 16-point mode (`cfg_size`=0), `cfg_ovl` has no effect and H is always 16.
- R5: In the cycle after `frame_ready`, a burst of N consecutive `rd_valid` cycles begins. `rd_idx` runs 0 to N-1. `rd_re`/`rd_im` carry the last N accepted samples in arrival order.
- R6: Cycles with `in_valid` low neither store a sample nor advance any frame count.
- R7: A frame that completes while a readout is in progress and not in its final cycle is dropped. No `frame_ready` is raised for it. `overrun` goes high and stays high until reset.
- R8: `cfg_size` and `cfg_ovl` are sampled until the first sample is accepted. Later changes have no effect until reset.
- R9: Sample loading continues during a readout without corrupting the frame being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 2 | Frame size select: 0=16, 1=64, 2/3=256 |
| cfg_ovl | input | 2 | Overlap select: 0=none, 1=half, 2=three quarters, 3=none |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | 16 | Input real component |
| in_im | input | 16 | Input imaginary component |
| frame_ready | output | 1 | One-cycle pulse when a frame is accepted for readout |
| rd_valid | output | 1 | Readout sample valid |
| rd_idx | output | 8 | Position of the readout sample within its frame |
| rd_re | output | 16 | Readout real component |
| rd_im | output | 16 | Readout imaginary component |
| overrun | output | 1 | Sticky flag: a completed frame was dropped |

## Verification
Continuous input with no overlap tests the back-to-back handover, where a new frame starts in the same cycle as the final read of the previous one. Gapped input at one half and one quarter rate in the overlap modes shows that frame spacing is counted in samples rather than cycles. Those runs also check readout data against sample positions while writes land in the same store. A 16-point run with overlap requested would overrun if the setting leaked through, so it separates a correct mode lock from a wrong hop. A continuous 50% run provokes the drop path, and a configuration change after the first sample checks the freeze.

// File: rtl/ofb_pkg.sv
package ofb_pkg;

  typedef struct packed {
    logic [1:0] sz;
    logic [1:0] ovl;
  } cfg_t;

  // log2 of frame length for a size code, clamped to the largest size
  function automatic int len_log(input logic [1:0] sz, input int log_min, input int nsizes);
    int s;
    s = (int'(sz) >= nsizes) ? nsizes - 1 : int'(sz);
    return log_min + 2 * s;
  endfunction

  // log2 of hop length: smallest size and code 3 mean no overlap
  function automatic int hop_log(input int lg, input logic [1:0] sz, input logic [1:0] ovl);
    if (sz == 2'd0 || ovl == 2'd3) return lg;
    return lg - int'(ovl);
  endfunction

endpackage

// File: rtl/ofb_mem.sv
module ofb_mem #(
  parameter int W  = 32,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ofb_ctrl.sv
module ofb_ctrl
  import ofb_pkg::*;
#(
  parameter int LOG_MIN   = 4,
  parameter int NUM_SIZES = 3,
  parameter int AW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_size,
  input  logic [1:0]    cfg_ovl,
  input  logic          in_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          frm_evt,
  output logic [AW-1:0] frm_base,
  output logic [AW-1:0] frm_len,
  output logic [AW-1:0] wrap_mask,
  output logic          started
);
  localparam logic [AW-1:0] ONE = 1;

  cfg_t          cfg_q, cfg_eff;
  logic [AW-1:0] wp, cnt, hop_len, target;
  logic          primed;
  int            lg, hl;

  always_comb begin
    cfg_eff   = started ? cfg_q : '{sz: cfg_size, ovl: cfg_ovl};
    lg        = len_log(cfg_eff.sz, LOG_MIN, NUM_SIZES);
    hl        = hop_log(lg, cfg_eff.sz, cfg_eff.ovl);
    frm_len   = ONE << lg;
    hop_len   = ONE << hl;
    wrap_mask = (ONE << (lg + 1)) - ONE;
    target    = primed ? hop_len : frm_len;
  end

  assign wr_en    = in_valid;
  assign wr_addr  = wp;
  assign frm_evt  = in_valid && ((cnt + ONE) == target);
  assign frm_base = (wp + ONE - frm_len) & wrap_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      started <= 1'b0;
      primed  <= 1'b0;
      wp      <= '0;
      cnt     <= '0;
    end else begin
      if (!started) cfg_q <= '{sz: cfg_size, ovl: cfg_ovl};
      if (in_valid) begin
        started <= 1'b1;
        wp      <= (wp + ONE) & wrap_mask;
        cnt     <= frm_evt ? '0 : cnt + ONE;
        if (frm_evt) primed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ofb_rd.sv
module ofb_rd #(
  parameter int AW = 9,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_evt,
  input  logic [AW-1:0] frm_base,
  input  logic [AW-1:0] frm_len,
  input  logic [AW-1:0] wrap_mask,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          drop_evt,
  output logic          frame_ready,
  output logic          rd_valid,
  output logic [IW-1:0] rd_idx,
  output logic          overrun
);
  localparam logic [AW-1:0] ONE = 1;

  logic          busy, last, start;
  logic [AW-1:0] base, rcnt;

  assign last     = busy && (rcnt == frm_len - ONE);
  assign start    = frm_evt && (!busy || last);
  assign drop_evt = frm_evt && busy && !last;
  assign rd_en    = busy;
  assign rd_addr  = (base + rcnt) & wrap_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      base        <= '0;
      rcnt        <= '0;
      frame_ready <= 1'b0;
      rd_valid    <= 1'b0;
      rd_idx      <= '0;
      overrun     <= 1'b0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        base <= frm_base;
        rcnt <= '0;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        rcnt <= rcnt + ONE;
      end
      frame_ready <= start;
      rd_valid    <= busy;
      rd_idx      <= rcnt[IW-1:0];
      overrun     <= overrun | drop_evt;
    end
  end
endmodule

// File: rtl/ovl_frame_buf.sv
module ovl_frame_buf #(
  parameter int DATA_W    = 16,
  parameter int LOG_MIN   = 4,
  parameter int NUM_SIZES = 3,
  localparam int LOG_MAX  = LOG_MIN + 2 * (NUM_SIZES - 1),
  localparam int AW       = LOG_MAX + 1,
  localparam int IW       = LOG_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic [1:0]        cfg_ovl,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              frame_ready,
  output logic              rd_valid,
  output logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_re,
  output logic [DATA_W-1:0] rd_im,
  output logic              overrun
);
  // named internal events, also observed by the bound checker
  logic          wr_en, frm_evt, drop_evt, started, rd_en;
  logic [AW-1:0] wr_addr, frm_base, frm_len, wrap_mask, rd_addr;
  logic [2*DATA_W-1:0] rd_word;

  ofb_ctrl #(.LOG_MIN(LOG_MIN), .NUM_SIZES(NUM_SIZES), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_ovl(cfg_ovl),
    .in_valid(in_valid), .wr_en(wr_en), .wr_addr(wr_addr),
    .frm_evt(frm_evt), .frm_base(frm_base), .frm_len(frm_len),
    .wrap_mask(wrap_mask), .started(started)
  );

  ofb_rd #(.AW(AW), .IW(IW)) u_rd (
    .clk(clk), .rst_n(rst_n), .frm_evt(frm_evt), .frm_base(frm_base),
    .frm_len(frm_len), .wrap_mask(wrap_mask), .rd_en(rd_en),
    .rd_addr(rd_addr), .drop_evt(drop_evt), .frame_ready(frame_ready),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .overrun(overrun)
  );

  ofb_mem #(.W(2 * DATA_W), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data({in_re, in_im}),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_word)
  );

  assign rd_re = rd_word[2*DATA_W-1:DATA_W];
  assign rd_im = rd_word[DATA_W-1:0];
endmodule

// File: rtl/ovl_frame_buf_chk.sv
module ovl_frame_buf_chk #(
  parameter int AW = 9,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_ready,
  input logic          rd_valid,
  input logic [IW-1:0] rd_idx,
  input logic          overrun,
  input logic          drop_evt,
  input logic          started,
  input logic [AW-1:0] frm_len
);
  localparam logic [AW-1:0] ONE  = 1;
  localparam logic [IW-1:0] IONE = 1;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> !frame_ready); // R2

  AST_RD_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> (rd_valid && rd_idx == '0)); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && ({1'b0, rd_idx} != frm_len - ONE)) |=> (rd_valid && rd_idx == $past(rd_idx) + IONE)); // R5

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (!frame_ready && overrun)); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> $stable(frm_len)); // R8
endmodule

bind ovl_frame_buf ovl_frame_buf_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready), .rd_valid(rd_valid),
  .rd_idx(rd_idx), .overrun(overrun), .drop_evt(drop_evt),
  .started(started), .frm_len(frm_len)
);

// File: tb/sim_ovl_frame_buf.sv
`timescale 1ns/1ps
module sim_ovl_frame_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_size = 2'd0, cfg_ovl = 2'd0;
  logic        in_valid = 1'b0;
  logic [15:0] in_re = '0, in_im = '0;
  logic        frame_ready, rd_valid, overrun;
  logic [7:0]  rd_idx;
  logic [15:0] rd_re, rd_im;

  int errors = 0, checks = 0;
  int sent = 0, cur_n = 16, cur_h = 16, cur_end = 0, rd_exp = 0;
  int rdy_cnt = 0, rdy_bad = 0, rdy_bad_val = 0, rd_total = 0, rd_bad = 0;
  bit pos_chk = 1'b1;

  always #4 clk = ~clk;

  ovl_frame_buf u0 (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_ovl(cfg_ovl),
    .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .frame_ready(frame_ready), .rd_valid(rd_valid), .rd_idx(rd_idx),
    .rd_re(rd_re), .rd_im(rd_im), .overrun(overrun)
  );

  function automatic logic [15:0] pat_re(input int k);
    return 16'(k * 37 + 5);
  endfunction
  function automatic logic [15:0] pat_im(input int k);
    return 16'(k) ^ 16'h5a5a;
  endfunction

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (rd_valid) begin
        int e;
        e = cur_end - cur_n + rd_exp;
        if (int'(rd_idx) != rd_exp || rd_re != pat_re(e) || rd_im != pat_im(e)) rd_bad++;
        rd_exp++;
        rd_total++;
      end
      if (frame_ready) begin
        if (pos_chk && sent != cur_n + rdy_cnt * cur_h) begin
          rdy_bad++;
          rdy_bad_val = sent;
        end
        rdy_cnt++;
        cur_end = sent;
        rd_exp = 0;
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sz, input logic [1:0] ov, input int n, input int h);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    cfg_size = sz; cfg_ovl = ov;
    repeat (3) @(negedge clk);
    sent = 0; cur_n = n; cur_h = h; cur_end = 0; rd_exp = 0;
    rdy_cnt = 0; rdy_bad = 0; rdy_bad_val = 0; rd_total = 0; rd_bad = 0;
    pos_chk = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic send(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = pat_re(sent); in_im = pat_im(sent);
      sent++;
      if (gap > 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (300) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset(2'd1, 2'd0, 64, 64);
    @(negedge clk);
    check(frame_ready == 1'b0, "R1 frame_ready after reset", int'(frame_ready), 0);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    check(overrun == 1'b0, "R1 overrun after reset", int'(overrun), 0);
  endtask

  task automatic t_mode(input logic [1:0] sz, input logic [1:0] ov, input int n, input int h,
                        input int nsamp, input int gap, input int frames, input string tag);
    do_reset(sz, ov, n, h);
    send(nsamp, gap);
    check(rdy_cnt == frames, {tag, " frame count"}, rdy_cnt, frames);
    check(rdy_bad == 0, {tag, " frame_ready position in samples"}, rdy_bad_val, 0);
    check(rd_bad == 0, {tag, " R5 readout order and data"}, rd_bad, 0);
    check(rd_total == frames * n, {tag, " R5 readout length"}, rd_total, frames * n);
    check(overrun == 1'b0, {tag, " R7 no overrun"}, int'(overrun), 0);
  endtask

  task automatic t_overrun();
    do_reset(2'd1, 2'd1, 64, 32);
    pos_chk = 1'b0;
    send(128, 0);
    check(overrun == 1'b1, "R7 overrun raised", int'(overrun), 1);
    check(rdy_cnt == 2, "R7 dropped frame gives no pulse", rdy_cnt, 2);
    check(rd_bad == 0 && rd_total == 128, "R7 kept frames read intact", rd_total, 128);
  endtask

  task automatic t_cfg_freeze();
    do_reset(2'd0, 2'd0, 16, 16);
    send(1, 0);
    cfg_size = 2'd2; cfg_ovl = 2'd2;
    send(31, 0);
    check(rdy_cnt == 2, "R8 config change after first sample ignored", rdy_cnt, 2);
    check(rdy_bad == 0 && rd_total == 32, "R8 frames stay 16 points", rd_total, 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    // R2 R3: 64 points, no overlap, continuous (back-to-back handover)
    t_mode(2'd1, 2'd0, 64, 64, 256, 0, 4, "R2 R3 64pt 0%");
    // R3 R6 R9: 64 points, half overlap, half-rate input
    t_mode(2'd1, 2'd1, 64, 32, 192, 1, 5, "R3 R6 R9 64pt 50%");
    // R3 R6 R9: 256 points, three-quarter overlap, quarter-rate input
    t_mode(2'd2, 2'd2, 256, 64, 448, 3, 4, "R3 R6 R9 256pt 75%");
    // R4: 16 points with overlap requested, hop stays 16
    t_mode(2'd0, 2'd2, 16, 16, 64, 0, 4, "R4 16pt overlap ignored");
    t_overrun();
    t_cfg_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule